// File: doc/BRIEF.md
# Conversion Result Holding Register with Coherent Byte Access

This block sits between a converter controller and an 8-bit register bus. The controller hands it a 10-bit result together with a one-cycle valid strobe. The block keeps the latest result and shows it to software as two byte-wide registers: a low byte and a high byte. A left-adjust control picks how the 10 bits are placed across the 16 bits of the two registers. Software sets the left-adjust control when it only needs the eight most significant bits, which it can then take from the high byte alone.

Software can read the two bytes one after the other while new results keep arriving. To keep the pair coherent, a read of the low byte locks the visible pair until the high byte is read. A result that completes during the lock is held in a one-entry shadow register. A newer arrival replaces the shadow. When the high-byte read releases the lock, the held result moves into the visible pair.

Top module: `conv_result_hold`

## Requirements
- R1: After reset the visible result is zero and the pair is unlocked, so reading the low byte and then the high byte returns 0x00 for both.
- R2: With `leftAdj` = 0, the low byte is result bits [7:0]. The high byte carries result bits [9:8] in bits [1:0], and high-byte bits [7:2] are 0.
- R3: With `leftAdj` = 1, the high byte is result bits [9:2]. The low byte carries result bits [1:0] in bits [7:6], and low-byte bits [5:0] are 0.
- R4: While unlocked, a `resValid` pulse with no low-byte read in the same cycle loads `resData` into the visible pair at that clock edge. A read in any later cycle returns the new value.
- R5: A low-byte read sets the lock at its clock edge. Until the lock is released, every read, including a repeated low-byte read, returns the value that was visible when the lock was set, whatever results arrive.
- R6: A high-byte read while locked returns the locked value and clears the lock at its edge. If a result arrived during the lock, that result is visible from the next cycle.
- R7: When several results arrive during one lock, only the last one becomes visible after the release.
- R8: A high-byte read while unlocked returns the current value and leaves the pair unlocked, so a later result updates the visible pair at once.
- R9: A result that arrives in the same cycle as the locking low-byte read is held in the shadow and does not reach the low byte just returned. A result that arrives in the same cycle as the releasing high-byte read becomes visible directly and takes precedence over the shadow.
- R10: `rdData` is 0x00 in any cycle where neither read strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | One-cycle strobe: `resData` holds a finished result |
| resData | input | 10 | Result from the conversion controller |
| leftAdj | input | 1 | 1 selects left-justified packing, 0 right-justified |
| rdLo | input | 1 | Low-byte read strobe |
| rdHi | input | 1 | High-byte read strobe |
| rdData | output | 8 | Byte returned in the cycle of a read strobe |

## Verification
The properties assume that the bus never raises `rdLo` and `rdHi` in the same cycle, because the two strobes decode separate addresses. The stimulus drives at most one read strobe per cycle. It also assumes `leftAdj` is a static setting, so it stays constant across any lock-to-release sequence. The bench changes `leftAdj` only between complete read pairs. The properties tie each visible-result change to a load from the input or from the shadow, and they check the lock state after every read.

// File: rtl/conv_result_pkg.sv
package conv_result_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic visFromIn;     // load visible pair from incoming result
    logic visFromShadow; // load visible pair from shadow register
    logic shadowLoad;    // capture incoming result into shadow
  } holdCtrl_t;

endpackage

// File: rtl/conv_result_ctrl.sv
module conv_result_ctrl
  import conv_result_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      resValid,
  input  logic      rdLo,
  input  logic      rdHi,
  output holdCtrl_t ctrl,
  output logic      locked,
  output logic      shadowFull
);

  logic release_;
  logic lockNext;
  logic shadowNext;

  // A high-byte read only releases a pair that a low-byte read locked.
  assign release_ = locked && rdHi;

  always_comb begin
    ctrl = '0;
    // Direct load is allowed when unlocked or at the release edge, but never
    // in the cycle that the low byte is being read (it would tear the pair).
    ctrl.visFromIn     = resValid && !rdLo && (!locked || release_);
    ctrl.shadowLoad    = resValid && !ctrl.visFromIn;
    ctrl.visFromShadow = release_ && shadowFull && !resValid;
  end

  always_comb begin
    lockNext = locked;
    if (rdLo) begin
      lockNext = 1'b1;
    end else if (release_) begin
      lockNext = 1'b0;
    end
  end

  always_comb begin
    shadowNext = shadowFull;
    if (release_) begin
      shadowNext = 1'b0;
    end else if (ctrl.shadowLoad) begin
      shadowNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked     <= 1'b0;
      shadowFull <= 1'b0;
    end else begin
      locked     <= lockNext;
      shadowFull <= shadowNext;
    end
  end

endmodule

// File: rtl/conv_result_data.sv
module conv_result_data
  import conv_result_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  holdCtrl_t        ctrl,
  input  logic [RES_W-1:0] resData,
  input  logic             leftAdj,
  input  logic             rdLo,
  input  logic             rdHi,
  output logic [BUS_W-1:0] rdData,
  output logic [RES_W-1:0] visRes,
  output logic [RES_W-1:0] shadowRes
);

  localparam int PACK_W = 2 * BUS_W;
  localparam int PAD_W  = PACK_W - RES_W;

  logic [PACK_W-1:0] rightWord;
  logic [PACK_W-1:0] leftWord;
  logic [PACK_W-1:0] packWord;

  // Result storage: visible pair and one-deep shadow.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      visRes <= '0;
    end else if (ctrl.visFromIn) begin
      visRes <= resData;
    end else if (ctrl.visFromShadow) begin
      visRes <= shadowRes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowRes <= '0;
    end else if (ctrl.shadowLoad) begin
      shadowRes <= resData;
    end
  end

  // Packing into the two bus-wide registers.
  generate
    if (PAD_W > 0) begin : g_pad
      assign rightWord = {{PAD_W{1'b0}}, visRes};
      assign leftWord  = rightWord << PAD_W;
    end else begin : g_nopad
      assign rightWord = visRes;
      assign leftWord  = visRes;
    end
  endgenerate

  assign packWord = leftAdj ? leftWord : rightWord;

  always_comb begin
    rdData = '0;
    if (rdLo) begin
      rdData = packWord[BUS_W-1:0];
    end else if (rdHi) begin
      rdData = packWord[PACK_W-1:BUS_W];
    end
  end

endmodule

// File: rtl/conv_result_hold.sv
module conv_result_hold
  import conv_result_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resValid,
  input  logic [RES_W-1:0] resData,
  input  logic             leftAdj,
  input  logic             rdLo,
  input  logic             rdHi,
  output logic [BUS_W-1:0] rdData
);

  holdCtrl_t        ctrl;
  logic             locked;
  logic             shadowFull;
  logic [RES_W-1:0] visRes;
  logic [RES_W-1:0] shadowRes;

  conv_result_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resValid   (resValid),
    .rdLo       (rdLo),
    .rdHi       (rdHi),
    .ctrl       (ctrl),
    .locked     (locked),
    .shadowFull (shadowFull)
  );

  conv_result_data #(
    .RES_W (RES_W),
    .BUS_W (BUS_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .resData   (resData),
    .leftAdj   (leftAdj),
    .rdLo      (rdLo),
    .rdHi      (rdHi),
    .rdData    (rdData),
    .visRes    (visRes),
    .shadowRes (shadowRes)
  );

endmodule

// File: rtl/conv_result_hold_chk.sv
module conv_result_hold_chk #(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             resValid,
  input logic [RES_W-1:0] resData,
  input logic             rdLo,
  input logic             rdHi,
  input logic [BUS_W-1:0] rdData,
  input logic             locked,
  input logic             shadowFull,
  input logic [RES_W-1:0] visRes,
  input logic [RES_W-1:0] shadowRes
);

  p_update_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && resValid && !rdLo) |=> (visRes == $past(resData)));

  p_lock_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdLo |=> locked);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !rdHi) |=> $stable(visRes));

  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && rdHi) |=> !locked);

  p_shadow_move_r6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && rdHi && shadowFull && !resValid) |=> (visRes == $past(shadowRes)));

  p_newest_r7: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !rdHi && resValid) |=> (shadowFull && shadowRes == $past(resData)));

  p_hi_nolock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && rdHi && !rdLo) |=> !locked);

  p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && rdLo && resValid) |=> ($stable(visRes) && shadowFull));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!rdLo && !rdHi) |-> (rdData == '0));

endmodule

bind conv_result_hold conv_result_hold_chk #(
  .RES_W (RES_W),
  .BUS_W (BUS_W)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .resValid   (resValid),
  .resData    (resData),
  .rdLo       (rdLo),
  .rdHi       (rdHi),
  .rdData     (rdData),
  .locked     (locked),
  .shadowFull (shadowFull),
  .visRes     (visRes),
  .shadowRes  (shadowRes)
);

// File: tb/conv_result_hold_test.sv
module conv_result_hold_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       resValid = 1'b0;
  logic [9:0] resData = '0;
  logic       leftAdj = 1'b0;
  logic       rdLo = 1'b0;
  logic       rdHi = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  conv_result_hold uut (
    .clk      (clk),
    .rstN     (rstN),
    .resValid (resValid),
    .resData  (resData),
    .leftAdj  (leftAdj),
    .rdLo     (rdLo),
    .rdHi     (rdHi),
    .rdData   (rdData)
  );

  function automatic logic [7:0] expLo(logic [9:0] v, logic la);
    return la ? {v[1:0], 6'b0} : v[7:0];
  endfunction

  function automatic logic [7:0] expHi(logic [9:0] v, logic la);
    return la ? v[9:2] : {6'b0, v[9:8]};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One read cycle; the strobe is live across exactly one rising edge.
  task automatic readByte(input bit hi, output logic [7:0] v);
    @(negedge clk);
    rdLo = !hi;
    rdHi = hi;
    #1 v = rdData;
    @(negedge clk);
    rdLo = 1'b0;
    rdHi = 1'b0;
  endtask

  task automatic push(input logic [9:0] val);
    @(negedge clk);
    resValid = 1'b1;
    resData  = val;
    @(negedge clk);
    resValid = 1'b0;
  endtask

  task automatic checkPair(string req, logic [9:0] val);
    logic [7:0] v;
    readByte(1'b0, v);
    check(req, v, expLo(val, leftAdj));
    readByte(1'b1, v);
    check(req, v, expHi(val, leftAdj));
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1 check("R10 idle", rdData, 8'h00);
    checkPair("R1 reset", 10'h000);
  endtask

  task automatic t_right;
    leftAdj = 1'b0;
    push(10'h2A5);
    checkPair("R2 right adjust", 10'h2A5);
    push(10'h15A);
    checkPair("R4 update", 10'h15A);
  endtask

  task automatic t_left;
    leftAdj = 1'b1;
    push(10'h2A5);
    checkPair("R3 left adjust", 10'h2A5);
    push(10'h3FF);
    checkPair("R3 left all ones", 10'h3FF);
    leftAdj = 1'b0;
  endtask

  task automatic t_lock;
    logic [7:0] v;
    push(10'h123);
    readByte(1'b0, v);
    check("R5 low", v, expLo(10'h123, 1'b0));
    push(10'h3C4);
    readByte(1'b0, v);
    check("R5 reread low", v, expLo(10'h123, 1'b0));
    readByte(1'b1, v);
    check("R6 high locked", v, expHi(10'h123, 1'b0));
    checkPair("R6 shadow visible", 10'h3C4);
  endtask

  task automatic t_newest;
    logic [7:0] v;
    push(10'h0F0);
    readByte(1'b0, v);
    push(10'h111);
    push(10'h2EE);
    readByte(1'b1, v);
    check("R7 high before", v, expHi(10'h0F0, 1'b0));
    checkPair("R7 newest", 10'h2EE);
  endtask

  task automatic t_hi_only;
    logic [7:0] v;
    push(10'h1AB);
    readByte(1'b1, v);
    check("R8 high only", v, expHi(10'h1AB, 1'b0));
    push(10'h35C);
    readByte(1'b1, v);
    check("R8 not locked", v, expHi(10'h35C, 1'b0));
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    push(10'h0D7);
    // Result and locking low read in the same cycle.
    @(negedge clk);
    rdLo = 1'b1;
    resValid = 1'b1;
    resData = 10'h26B;
    #1 v = rdData;
    @(negedge clk);
    rdLo = 1'b0;
    resValid = 1'b0;
    check("R9 low same cycle", v, expLo(10'h0D7, 1'b0));
    readByte(1'b1, v);
    check("R9 high same cycle", v, expHi(10'h0D7, 1'b0));
    checkPair("R9 shadow after", 10'h26B);
    // Result during lock, then another result with the releasing read.
    readByte(1'b0, v);
    push(10'h099);
    @(negedge clk);
    rdHi = 1'b1;
    resValid = 1'b1;
    resData = 10'h3A1;
    #1 v = rdData;
    @(negedge clk);
    rdHi = 1'b0;
    resValid = 1'b0;
    check("R9 high at release", v, expHi(10'h26B, 1'b0));
    checkPair("R9 direct wins", 10'h3A1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_right();
    t_left();
    t_lock();
    t_newest();
    t_hi_only();
    t_same_cycle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule